// File: doc/BRIEF.md
# Direct-Mapped Cache Lookup with XOR-Hashed Set Selection

This block is the tag side of a direct-mapped, demand-fetching cache whose set is not picked by the low block-address bits alone. Each set-index bit is the matching low block-address bit, XORed with at most one block-address bit taken from above the index field. A static configuration word chooses that bit. Lines are 32 bytes, so the five lowest byte-address bits are the offset. The index width parameter sets the capacity: 5, 7 or 9 index bits give 1 KB, 4 KB or 16 KB.

A lookup enters on a valid/ready request channel. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. The caller holds `req_valid` and `req_addr` steady until then. Every accepted request yields a one-cycle `rsp_valid` pulse with a hit flag in the next cycle, whatever the configuration is. A miss makes the block ask for the line on a refill channel that also uses valid/ready. It then waits for a completion pulse, and at that pulse it writes the tag and marks the set valid. While a refill is pending, `req_ready` stays low. It also stays low in any cycle where the hash configuration differs from the one last captured. The block clears all lines before it accepts the next request under the new mapping.

The stored tag is the whole block address above the index field. Each index bit is an invertible function of the low bits and the tag, so the tag and the set together identify the block.

Top module: `hashed_dm_cache`

## Requirements
- R1: Index bit k equals block-address bit k XOR block-address bit (IDX_W + s - 1), where s is the field `hash_cfg[k*SEL_W +: SEL_W]`. A field value of 0, or any value above the number of upper bits, means no XOR.
- R2: Each accepted request produces `rsp_valid` high for exactly one cycle, in the cycle right after the accepting edge, and `rsp_valid` is low otherwise. The latency is the same for every configuration.
- R3: After reset every line is invalid, so the first access to any block reports a miss.
- R4: On a miss, `mreq_valid` rises in the cycle after acceptance with `mreq_addr` = byte address bits [ADDR_W-1:5]. Both stay steady until the edge where `mreq_ready` is high.
- R5: When `fill_valid` arrives, the block installs the missed line, and the next access to that block reports a hit.
- R6: `req_ready` is low from the cycle after a miss is accepted until the cycle after `fill_valid`.
- R7: The five offset bits do not affect the result. Another byte in a resident line hits.
- R8: Two blocks that map to the same set evict each other.
- R9: A change of `hash_cfg` holds `req_ready` low for that cycle and clears all lines, so a block resident before the change misses afterwards.
- R10: A selected upper bit can split blocks that would conflict under plain low-bit indexing, so both stay resident and hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hash_cfg | input | IDX_W*SEL_W | Per-index-bit XOR source select |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can take a lookup |
| req_addr | input | ADDR_W | Byte address of lookup |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| mreq_valid | output | 1 | Refill request present |
| mreq_ready | input | 1 | Refill request taken |
| mreq_addr | output | ADDR_W-5 | Block address to refill |
| fill_valid | input | 1 | Refill complete |

## Verification
Two events can land in the same cycle. One is a change of the hash configuration. The other is the edge where a lookup would be taken, while lines filled under the old mapping are still valid. The bench changes `hash_cfg` between accesses to blocks that are already resident. It checks that `req_ready` drops in that cycle, and that the next access to a block resident before the change reports a miss. The bench then shows the new mapping at the ports. Two blocks conflict or stay apart in the cache depending on the selected XOR bit.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_ASK  = 2'd1,
    FILL_WAIT = 2'd2
  } fill_state_t;
endpackage

// File: rtl/xor_index_hash.sv
module xor_index_hash #(
  parameter int BLK_W = 27,
  parameter int IDX_W = 5,
  parameter int HI_W  = BLK_W - IDX_W,
  parameter int SEL_W = $clog2(HI_W + 1)
) (
  input  logic [BLK_W-1:0]       blk,
  input  logic [IDX_W*SEL_W-1:0] cfg,
  output logic [IDX_W-1:0]       idx
);
  for (genvar k = 0; k < IDX_W; k++) begin : g_bit
    logic [SEL_W-1:0] sel;
    logic             extra;
    assign sel = cfg[k*SEL_W +: SEL_W];
    // one-of-HI_W select; the mux depth is fixed, so latency is independent of cfg
    always_comb begin
      extra = 1'b0;
      for (int j = 0; j < HI_W; j++) begin
        if (sel == SEL_W'(j + 1)) extra = blk[IDX_W + j];
      end
    end
    assign idx[k] = blk[k] ^ extra;
  end
endmodule

// File: rtl/line_store.sv
module line_store #(
  parameter int IDX_W = 5,
  parameter int TAG_W = 22,
  parameter int SETS  = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/refill_fsm.sv
module refill_fsm
  import hdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_start,
  input  logic mreq_ready,
  input  logic fill_valid,
  output logic busy,
  output logic mreq_valid,
  output logic install
);
  fill_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FILL_IDLE: if (miss_start) st_d = FILL_ASK;
      FILL_ASK:  if (mreq_ready) st_d = FILL_WAIT;
      FILL_WAIT: if (fill_valid) st_d = FILL_IDLE;
      default:   st_d = FILL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FILL_IDLE;
    else        st_q <= st_d;
  end

  assign busy       = (st_q != FILL_IDLE);
  assign mreq_valid = (st_q == FILL_ASK);
  assign install    = (st_q == FILL_WAIT) && fill_valid;
endmodule

// File: rtl/hashed_dm_cache.sv
module hashed_dm_cache #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 5,
  parameter int IDX_W  = 5,
  localparam int BLK_W = ADDR_W - OFFS_W,
  localparam int HI_W  = BLK_W - IDX_W,
  localparam int SEL_W = $clog2(HI_W + 1),
  localparam int CFG_W = IDX_W * SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  hash_cfg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [BLK_W-1:0]  mreq_addr,
  input  logic              fill_valid
);
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_diff, flush, busy, accept, install;
  logic [BLK_W-1:0] blk, pend_blk_q;
  logic [IDX_W-1:0] idx, pend_idx_q;
  logic             line_valid, hit_now;
  logic [HI_W-1:0]  line_tag;
  logic             unused_offset;

  assign blk           = req_addr[ADDR_W-1:OFFS_W];
  assign unused_offset = ^req_addr[OFFS_W-1:0];

  assign cfg_diff  = (hash_cfg != cfg_q);
  assign flush     = cfg_diff && !busy;
  assign req_ready = !busy && !cfg_diff;
  assign accept    = req_valid && req_ready;

  xor_index_hash #(.BLK_W(BLK_W), .IDX_W(IDX_W), .HI_W(HI_W), .SEL_W(SEL_W)) u_hash (
    .blk(blk), .cfg(hash_cfg), .idx(idx)
  );

  line_store #(.IDX_W(IDX_W), .TAG_W(HI_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rd_idx(idx), .rd_valid(line_valid), .rd_tag(line_tag),
    .wr_en(install), .wr_idx(pend_idx_q), .wr_tag(pend_blk_q[BLK_W-1:IDX_W])
  );

  assign hit_now = line_valid && (line_tag == blk[BLK_W-1:IDX_W]);

  refill_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .miss_start(accept && !hit_now),
    .mreq_ready(mreq_ready), .fill_valid(fill_valid),
    .busy(busy), .mreq_valid(mreq_valid), .install(install)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      pend_blk_q <= '0;
      pend_idx_q <= '0;
    end else begin
      if (flush) cfg_q <= hash_cfg;
      rsp_valid <= accept;
      if (accept) begin
        rsp_hit <= hit_now;
        if (!hit_now) begin
          pend_blk_q <= blk;
          pend_idx_q <= idx;
        end
      end
    end
  end

  assign mreq_addr = pend_blk_q;
endmodule

// File: rtl/hdc_checker.sv
module hdc_checker #(
  parameter int BLK_W = 27,
  parameter int CFG_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] hash_cfg,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             mreq_valid,
  input logic             mreq_ready,
  input logic [BLK_W-1:0] mreq_addr
);
  a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  a_r4_miss_asks_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> mreq_valid);

  a_r4_mreq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)));

  a_r6_ready_low_in_refill: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> !req_ready);

  a_r9_ready_low_on_cfg_change: assert property (@(posedge clk) disable iff (!rst_n)
    (hash_cfg != $past(hash_cfg)) |-> !req_ready);
endmodule

bind hashed_dm_cache hdc_checker #(.BLK_W(BLK_W), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hash_cfg(hash_cfg),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr)
);

// File: tb/sim_hashed_dm_cache.sv
module sim_hashed_dm_cache;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 5;
  localparam int BLK_W  = ADDR_W - 5;
  localparam int SEL_W  = 5;
  localparam int CFG_W  = IDX_W * SEL_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CFG_W-1:0]  hash_cfg = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              rsp_valid, rsp_hit, mreq_valid;
  logic              mreq_ready = 1'b0;
  logic [BLK_W-1:0]  mreq_addr;
  logic              fill_valid = 1'b0;

  int checks = 0;
  int bad = 0;
  bit finished = 0;
  bit               exp_q[$];
  logic [BLK_W-1:0] blk_q[$];

  always #2 clk = ~clk;

  hashed_dm_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .hash_cfg(hash_cfg),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .fill_valid(fill_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: push the expected outcome, then hand the request over
  task automatic access(input logic [ADDR_W-1:0] a, input bit exp_hit, input string req);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(exp_hit);
    if (!exp_hit) blk_q.push_back(a[ADDR_W-1:5]);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R2", {req, " response one cycle after accept"}, rsp_valid, 1);
    if (!exp_hit)
      chk(req_ready == 1'b0, "R6", {req, " ready low after miss"}, req_ready, 0);
    while (!req_ready) @(negedge clk);
  endtask

  // monitor: compare results against the scoreboard queue
  initial forever begin
    @(negedge clk);
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected response", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk(rsp_hit == e, e ? "R5" : "R3", "hit flag", rsp_hit, e);
      end
    end
  end

  // refill responder
  initial forever begin
    @(negedge clk);
    if (rst_n && mreq_valid) begin
      logic [BLK_W-1:0] eb;
      eb = (blk_q.size() != 0) ? blk_q.pop_front() : '1;
      chk(mreq_addr == eb, "R4", "refill address", mreq_addr, eb);
      @(negedge clk);
      chk(mreq_valid && mreq_addr == eb, "R4", "refill request held", mreq_addr, eb);
      mreq_ready = 1'b1;
      @(negedge clk);
      mreq_ready = 1'b0;
      repeat (2) @(negedge clk);
      fill_valid = 1'b1;
      @(negedge clk);
      fill_valid = 1'b0;
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    finish_run();
  end

  localparam logic [31:0] A  = 32'h0000_0400; // blk 0x20, low idx 0
  localparam logic [31:0] B  = 32'h0000_0800; // blk 0x40, low idx 0
  localparam logic [31:0] E  = 32'h8000_0200; // blk bit26 set, low idx 16

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R3", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R2", "no response after reset", rsp_valid, 0);
    chk(mreq_valid == 1'b0, "R4", "no refill after reset", mreq_valid, 0);

    access(A, 1'b0, "R3");          // cold miss
    access(A + 32'd4, 1'b1, "R7");  // other offset, same line
    access(A + 32'd31, 1'b1, "R7");
    access(B, 1'b0, "R8");          // same set, evicts A
    access(A, 1'b0, "R8");          // A was evicted
    access(A, 1'b1, "R5");

    // R9/R10: bit0 XOR with block bit 6 (field 2); A -> set 0, B -> set 1
    hash_cfg = CFG_W'(2);
    #0;
    chk(req_ready == 1'b0, "R9", "ready low on config change", req_ready, 0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready back after flush", req_ready, 1);
    access(A, 1'b0, "R9");          // resident before, flushed now
    access(B, 1'b0, "R10");
    access(A, 1'b1, "R10");
    access(B, 1'b1, "R10");

    // R1: bit4 XOR with block bit 26 (field 22); E -> set 0, same as A
    hash_cfg = CFG_W'(22) << (4 * SEL_W);
    #0;
    chk(req_ready == 1'b0, "R9", "ready low on second change", req_ready, 0);
    @(negedge clk);
    access(A, 1'b0, "R1");
    access(E, 1'b0, "R1");
    access(A, 1'b0, "R1");          // E landed in set 0
    access(E, 1'b0, "R1");
    access(E, 1'b1, "R1");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "all responses seen", exp_q.size(), 0);
    chk(blk_q.size() == 0, "R4", "all refills seen", blk_q.size(), 0);
    finish_run();
  end
endmodule